// File: doc/BRIEF.md
# Two-Level Micro-Op Loop Sequencer

The sequencer turns one compute instruction into an ordered stream of buffer index triples (destination, source, weight). An instruction carries an outer iteration count, an inner iteration count, a half-open range of micro-op addresses, and an inner and an outer stride factor for each of the three indices. For every outer iteration, every inner iteration and every micro-op in the range, the block reads the micro-op word from its own small RAM and emits the three field values, each plus an affine offset built from the stride factors.

The micro-op RAM is loaded through a plain write port. An instruction is launched with a `start` pulse while the block is idle. Triples leave on a valid/ready stream together with the instruction's accumulator-clear flag. The downstream datapath uses that flag to write zero into the destination accumulator. The block raises `done` for one cycle when the instruction is complete.

The controller has four states. IDLE waits for `start`. FETCH issues a synchronous RAM read. EMIT presents the triple until it is accepted. DONE pulses completion. The transitions are:
- IDLE→FETCH on a `start` for a non-empty instruction.
- IDLE→DONE on a `start` for an empty instruction.
- FETCH→EMIT always.
- EMIT→FETCH on acceptance when triples remain.
- EMIT→DONE on acceptance of the final triple.
- DONE→IDLE always.

Top module: `uop_loop_seq`

## Requirements
- R1: After reset, `trip_valid`, `done` and `busy` are all 0.
- R2: Triples are emitted in nested order: the micro-op address runs from `uop_first` up to `uop_last_excl`-1 innermost, then the inner iteration, then the outer iteration.
- R3: A micro-op word holds the destination field in bits [IDX_W-1:0], the source field in bits [2*IDX_W-1:IDX_W] and the weight field in bits [3*IDX_W-1:2*IDX_W]. Each emitted index equals its field plus that index's current inner offset, modulo 2^IDX_W.
- R4: All offsets are zero when an instruction starts. At the start of every outer iteration, each inner offset restarts from its outer offset. So for outer iteration o and inner iteration i, the offset is o*outer_factor + i*inner_factor.
- R5: Destination, source and weight each use only their own pair of stride factors.
- R6: While `trip_valid` is 1 and `trip_ready` is 0, `trip_valid` stays 1 and all three indices hold their values.
- R7: `done` is 1 for exactly one cycle, in the cycle after the final triple is accepted. `busy` is 1 from the cycle after `start` until the end of that `done` cycle.
- R8: If either iteration count is zero, or if `uop_first` >= `uop_last_excl`, no triple is emitted and `done` is 1 in the cycle after `start`.
- R9: `trip_clear` equals the `clear_acc` value that was sampled with `start`, on every triple of that instruction.
- R10: While `busy` is 1, `start` and all instruction inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uop_we | input | 1 | Micro-op RAM write enable |
| uop_waddr | input | AW | Micro-op RAM write address |
| uop_wdata | input | 3*IDX_W | Micro-op word (dst, src, wgt fields) |
| start | input | 1 | Launch an instruction (sampled while idle) |
| iter_outer | input | ITER_W | Outer iteration count |
| iter_inner | input | ITER_W | Inner iteration count |
| uop_first | input | AW | First micro-op address |
| uop_last_excl | input | AW+1 | Micro-op end address, exclusive |
| dst_step_outer | input | IDX_W | Destination outer factor |
| dst_step_inner | input | IDX_W | Destination inner factor |
| src_step_outer | input | IDX_W | Source outer factor |
| src_step_inner | input | IDX_W | Source inner factor |
| wgt_step_outer | input | IDX_W | Weight outer factor |
| wgt_step_inner | input | IDX_W | Weight inner factor |
| clear_acc | input | 1 | Accumulator-clear flag of the instruction |
| trip_valid | output | 1 | Triple valid |
| trip_ready | input | 1 | Triple accepted by downstream |
| trip_dst | output | IDX_W | Destination index |
| trip_src | output | IDX_W | Source index |
| trip_wgt | output | IDX_W | Weight index |
| trip_clear | output | 1 | Accumulator-clear flag with the triple |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Instruction in progress |

## Verification
The assertions check the stream rules on every cycle:
- a stalled triple holds, and its valid stays up;
- `done` is a single-cycle pulse that never coincides with a valid triple;
- an idle block is quiet;
- the clear flag stays constant for a whole instruction.

Only the bench scenarios can show that the emitted indices follow the nested loop order with the correct affine offsets. They also cover modulo wrap of the indices, empty instructions, and the exact cycle of `done`. For each scenario the bench compares the stream with sequences it computes from the closed-form offset o*outer + i*inner.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_EMIT  = 2'd2,
        S_DONE  = 2'd3
    } seq_state_t;

    // lane order inside the micro-op word: destination, source, weight
    localparam int NUM_LANES = 3;

endpackage

// File: rtl/uop_ram.sv
module uop_ram #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 33,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/uop_offset_track.sv
module uop_offset_track #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step_in,
    input  logic             step_out,
    input  logic [IDX_W-1:0] fac_in,
    input  logic [IDX_W-1:0] fac_out,
    output logic [IDX_W-1:0] off_inner
);

    logic [IDX_W-1:0] off_outer;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            off_outer <= '0;
            off_inner <= '0;
        end else if (step_out) begin
            // new outer iteration: inner restarts from the advanced outer offset
            off_outer <= off_outer + fac_out;
            off_inner <= off_outer + fac_out;
        end else if (step_in) begin
            off_inner <= off_inner + fac_in;
        end
    end

endmodule

// File: rtl/uop_loop_seq.sv
module uop_loop_seq
    import uop_seq_pkg::*;
#(
    parameter int IDX_W     = 11,
    parameter int ITER_W    = 8,
    parameter int UOP_DEPTH = 64,
    localparam int AW       = $clog2(UOP_DEPTH),
    localparam int WORD_W   = NUM_LANES * IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uop_we,
    input  logic [AW-1:0]     uop_waddr,
    input  logic [WORD_W-1:0] uop_wdata,
    input  logic              start,
    input  logic [ITER_W-1:0] iter_outer,
    input  logic [ITER_W-1:0] iter_inner,
    input  logic [AW-1:0]     uop_first,
    input  logic [AW:0]       uop_last_excl,
    input  logic [IDX_W-1:0]  dst_step_outer,
    input  logic [IDX_W-1:0]  dst_step_inner,
    input  logic [IDX_W-1:0]  src_step_outer,
    input  logic [IDX_W-1:0]  src_step_inner,
    input  logic [IDX_W-1:0]  wgt_step_outer,
    input  logic [IDX_W-1:0]  wgt_step_inner,
    input  logic              clear_acc,
    output logic              trip_valid,
    input  logic              trip_ready,
    output logic [IDX_W-1:0]  trip_dst,
    output logic [IDX_W-1:0]  trip_src,
    output logic [IDX_W-1:0]  trip_wgt,
    output logic              trip_clear,
    output logic              done,
    output logic              busy
);

    seq_state_t state, state_nxt;

    // latched instruction
    logic [ITER_W-1:0] n_out_q, n_in_q;
    logic [AW-1:0]     first_q;
    logic [AW:0]       end_q;
    logic              clear_q;
    logic [IDX_W-1:0]  fac_in_q  [NUM_LANES];
    logic [IDX_W-1:0]  fac_out_q [NUM_LANES];

    // loop counters
    logic [AW-1:0]     upc;
    logic [ITER_W-1:0] cnt_in, cnt_out;

    logic empty_insn, launch, accept;
    logic last_u, last_in, last_out;
    logic step_in, step_out;

    logic [WORD_W-1:0] uop_word;
    logic [IDX_W-1:0]  off_in [NUM_LANES];
    logic [IDX_W-1:0]  idx_out [NUM_LANES];

    // ---------------- control terms ----------------
    always_comb begin
        empty_insn = (iter_outer == '0) || (iter_inner == '0) ||
                     ({1'b0, uop_first} >= uop_last_excl);
        launch     = (state == S_IDLE) && start && !empty_insn;
        accept     = (state == S_EMIT) && trip_ready;
        last_u     = ({1'b0, upc} + 1'b1) == end_q;
        last_in    = ({1'b0, cnt_in} + 1'b1) == {1'b0, n_in_q};
        last_out   = ({1'b0, cnt_out} + 1'b1) == {1'b0, n_out_q};
        step_in    = accept && last_u && !last_in;
        step_out   = accept && last_u && last_in && !last_out;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    state_nxt = empty_insn ? S_DONE : S_FETCH;
                end
            end
            S_FETCH: state_nxt = S_EMIT;
            S_EMIT: begin
                if (accept) begin
                    state_nxt = (last_u && last_in && last_out) ? S_DONE : S_FETCH;
                end
            end
            S_DONE:  state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        trip_valid = 1'b0;
        done       = 1'b0;
        busy       = 1'b1;
        unique case (state)
            S_IDLE:  busy       = 1'b0;
            S_FETCH: ;
            S_EMIT:  trip_valid = 1'b1;
            S_DONE:  done       = 1'b1;
            default: busy       = 1'b0;
        endcase
    end

    assign trip_clear = clear_q;
    assign trip_dst   = idx_out[0];
    assign trip_src   = idx_out[1];
    assign trip_wgt   = idx_out[2];

    // ---------------- instruction latch and counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_out_q <= '0;
            n_in_q  <= '0;
            first_q <= '0;
            end_q   <= '0;
            clear_q <= 1'b0;
            upc     <= '0;
            cnt_in  <= '0;
            cnt_out <= '0;
        end else if (launch) begin
            n_out_q <= iter_outer;
            n_in_q  <= iter_inner;
            first_q <= uop_first;
            end_q   <= uop_last_excl;
            clear_q <= clear_acc;
            upc     <= uop_first;
            cnt_in  <= '0;
            cnt_out <= '0;
        end else if (accept) begin
            if (!last_u) begin
                upc <= upc + 1'b1;
            end else begin
                upc <= first_q;
                if (!last_in) begin
                    cnt_in <= cnt_in + 1'b1;
                end else begin
                    cnt_in  <= '0;
                    cnt_out <= cnt_out + 1'b1;
                end
            end
        end
    end

    // ---------------- per-lane factor latch ----------------
    logic [IDX_W-1:0] fac_in_d  [NUM_LANES];
    logic [IDX_W-1:0] fac_out_d [NUM_LANES];

    always_comb begin
        fac_in_d[0]  = dst_step_inner;
        fac_in_d[1]  = src_step_inner;
        fac_in_d[2]  = wgt_step_inner;
        fac_out_d[0] = dst_step_outer;
        fac_out_d[1] = src_step_outer;
        fac_out_d[2] = wgt_step_outer;
    end

    // ---------------- micro-op memory ----------------
    uop_ram #(
        .DEPTH  (UOP_DEPTH),
        .WORD_W (WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (uop_we),
        .waddr (uop_waddr),
        .wdata (uop_wdata),
        .re    (state == S_FETCH),
        .raddr (upc),
        .rdata (uop_word)
    );

    // ---------------- per-lane offset and index ----------------
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fac_in_q[g]  <= '0;
                fac_out_q[g] <= '0;
            end else if (launch) begin
                fac_in_q[g]  <= fac_in_d[g];
                fac_out_q[g] <= fac_out_d[g];
            end
        end

        uop_offset_track #(
            .IDX_W (IDX_W)
        ) u_off (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (launch),
            .step_in   (step_in),
            .step_out  (step_out),
            .fac_in    (fac_in_q[g]),
            .fac_out   (fac_out_q[g]),
            .off_inner (off_in[g])
        );

        assign idx_out[g] = uop_word[g*IDX_W +: IDX_W] + off_in[g];
    end

endmodule

// File: rtl/uop_loop_seq_chk.sv
module uop_loop_seq_chk #(
    parameter int IDX_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trip_valid,
    input logic             trip_ready,
    input logic [IDX_W-1:0] trip_dst,
    input logic [IDX_W-1:0] trip_src,
    input logic [IDX_W-1:0] trip_wgt,
    input logic             trip_clear,
    input logic             done,
    input logic             busy
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_valid && !trip_ready) |=> (trip_valid && $stable(trip_dst) &&
                                         $stable(trip_src) && $stable(trip_wgt))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !trip_valid)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!trip_valid && !done)); // R1

    AST_CLEAR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(trip_clear)); // R9

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R7

endmodule

bind uop_loop_seq uop_loop_seq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_valid (trip_valid),
    .trip_ready (trip_ready),
    .trip_dst   (trip_dst),
    .trip_src   (trip_src),
    .trip_wgt   (trip_wgt),
    .trip_clear (trip_clear),
    .done       (done),
    .busy       (busy)
);

// File: tb/sim_uop_loop_seq.sv
`timescale 1ns/1ps
module sim_uop_loop_seq;

    localparam int IDX_W = 11;
    localparam int ITER_W = 8;
    localparam int DEPTH = 64;
    localparam int AW = 6;
    localparam int MASK = (1 << IDX_W) - 1;

    typedef struct packed {
        int io; int ii; int b; int e;
        int dfo; int dfi; int sfo; int sfi; int wfo; int wfi;
        int cl;
    } ent_t;

    localparam ent_t TBL [4] = '{
        '{2, 3, 0, 2, 10, 1, 20, 2, 30, 3, 0},
        '{3, 1, 5, 8, 4, 0, 0, 7, 1, 1, 1},
        '{1, 4, 2, 3, 0, 5, 0, 6, 0, 9, 0},
        '{2, 2, 60, 64, 2040, 3, 5, 2047, 100, 2000, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uop_we = 1'b0;
    logic [AW-1:0] uop_waddr = '0;
    logic [3*IDX_W-1:0] uop_wdata = '0;
    logic start = 1'b0;
    logic [ITER_W-1:0] iter_outer = '0, iter_inner = '0;
    logic [AW-1:0] uop_first = '0;
    logic [AW:0] uop_last_excl = '0;
    logic [IDX_W-1:0] dso = '0, dsi = '0, sso = '0, ssi = '0, wso = '0, wsi = '0;
    logic clear_acc = 1'b0;
    logic trip_valid, trip_ready = 1'b0;
    logic [IDX_W-1:0] trip_dst, trip_src, trip_wgt;
    logic trip_clear, done, busy;

    always #5 clk = ~clk;

    uop_loop_seq u0 (
        .clk(clk), .rst_n(rst_n), .uop_we(uop_we), .uop_waddr(uop_waddr),
        .uop_wdata(uop_wdata), .start(start), .iter_outer(iter_outer),
        .iter_inner(iter_inner), .uop_first(uop_first), .uop_last_excl(uop_last_excl),
        .dst_step_outer(dso), .dst_step_inner(dsi), .src_step_outer(sso),
        .src_step_inner(ssi), .wgt_step_outer(wso), .wgt_step_inner(wsi),
        .clear_acc(clear_acc), .trip_valid(trip_valid), .trip_ready(trip_ready),
        .trip_dst(trip_dst), .trip_src(trip_src), .trip_wgt(trip_wgt),
        .trip_clear(trip_clear), .done(done), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int md [DEPTH];
    int ms [DEPTH];
    int mw [DEPTH];
    int ed [1024];
    int es [1024];
    int ew [1024];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, act %0d exp below 100000 cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load_fields(input ent_t e);
        iter_outer = ITER_W'(e.io);
        iter_inner = ITER_W'(e.ii);
        uop_first = AW'(e.b);
        uop_last_excl = (AW+1)'(e.e);
        dso = IDX_W'(e.dfo); dsi = IDX_W'(e.dfi);
        sso = IDX_W'(e.sfo); ssi = IDX_W'(e.sfi);
        wso = IDX_W'(e.wfo); wsi = IDX_W'(e.wfi);
        clear_acc = e.cl[0];
    endtask

    // runs one instruction; compares stream, done timing, clear flag
    task automatic run(input ent_t e);
        int n_exp = 0;
        int got = 0;
        int cyc = 0;
        bit prev_last = 0;
        bit stalled = 0;
        logic [IDX_W-1:0] hd = '0, hs = '0, hw = '0;
        for (int o = 0; o < e.io; o++)
            for (int i = 0; i < e.ii; i++)
                for (int u = e.b; u < e.e; u++) begin
                    ed[n_exp] = (md[u] + o*e.dfo + i*e.dfi) & MASK;
                    es[n_exp] = (ms[u] + o*e.sfo + i*e.sfi) & MASK;
                    ew[n_exp] = (mw[u] + o*e.wfo + i*e.wfi) & MASK;
                    n_exp++;
                end
        load_fields(e);
        start = 1'b1;
        prev_last = (n_exp == 0);
        step();
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", busy, 1);
        while (1) begin
            cyc++;
            // R10: a start with scrambled fields while busy must be ignored
            if (cyc == 3) begin
                start = 1'b1; iter_outer = '0; iter_inner = 8'd9;
                uop_first = '0; uop_last_excl = 7'd40; dso = 11'd77; clear_acc = ~clear_acc;
            end else begin
                start = 1'b0;
            end
            trip_ready = ((cyc % 4) != 2);
            if (prev_last) begin
                chk(done == 1'b1, "R7/R8 done in cycle after last triple", done, 1);
                chk(trip_valid == 1'b0, "R8 no valid with done", trip_valid, 0);
                chk(got == n_exp, "R2 triple count", got, n_exp);
                break;
            end
            chk(done == 1'b0, "R7 no early done", done, 0);
            if (stalled) begin
                chk(trip_valid && trip_dst == hd && trip_src == hs && trip_wgt == hw,
                    "R6 stalled triple held", trip_dst, hd);
            end
            stalled = 0;
            if (trip_valid && !trip_ready) begin
                stalled = 1; hd = trip_dst; hs = trip_src; hw = trip_wgt;
            end
            if (trip_valid && trip_ready) begin
                if (got < n_exp) begin
                    chk(trip_dst == IDX_W'(ed[got]), "R3 R4 dst index", trip_dst, ed[got]);
                    chk(trip_src == IDX_W'(es[got]), "R5 src index", trip_src, es[got]);
                    chk(trip_wgt == IDX_W'(ew[got]), "R5 wgt index", trip_wgt, ew[got]);
                    chk(trip_clear == e.cl[0], "R9 clear flag", trip_clear, e.cl);
                end else begin
                    chk(0, "R2 extra triple", got, n_exp);
                end
                got++;
                prev_last = (got == n_exp);
            end
            step();
        end
        trip_ready = 1'b0;
        step();
        chk(busy == 1'b0 && done == 1'b0, "R7 idle after done", busy, 0);
    endtask

    initial begin
        step();
        step();
        chk(trip_valid == 1'b0, "R1 valid after reset", trip_valid, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        rst_n = 1'b1;
        step();
        // load micro-op RAM with computed contents
        for (int k = 0; k < DEPTH; k++) begin
            md[k] = (2*k) & MASK;
            ms[k] = (k + 500) & MASK;
            mw[k] = (MASK - k) & MASK;
            uop_we = 1'b1;
            uop_waddr = AW'(k);
            uop_wdata = {IDX_W'(mw[k]), IDX_W'(ms[k]), IDX_W'(md[k])};
            step();
        end
        uop_we = 1'b0;
        chk(trip_valid == 1'b0 && busy == 1'b0, "R1 RAM load leaves block idle", busy, 0);

        // table of instructions (R2 R3 R4 R5 R9 and wrap)
        for (int t = 0; t < 4; t++) begin
            run(TBL[t]);
        end

        // directed: empty instructions (R8)
        run('{0, 3, 0, 2, 1, 1, 1, 1, 1, 1, 0});
        run('{2, 0, 0, 2, 1, 1, 1, 1, 1, 1, 1});
        run('{1, 1, 4, 4, 1, 1, 1, 1, 1, 1, 0});
        run('{1, 1, 6, 3, 1, 1, 1, 1, 1, 1, 0});

        // directed: single triple, full range end, zero factors
        run('{1, 1, 63, 64, 0, 0, 0, 0, 0, 0, 1});

        // directed: reset in the middle of an instruction returns to idle (R1)
        load_fields('{2, 2, 0, 4, 1, 1, 1, 1, 1, 1, 0});
        start = 1'b1;
        step();
        start = 1'b0;
        step();
        rst_n = 1'b0;
        step();
        chk(trip_valid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 mid-run reset", busy, 0);
        rst_n = 1'b1;
        step();
        run(TBL[0]);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule